// File: doc/BRIEF.md
# Timer compare toggle flip-flop unit

This block is a 16-bit up-counter with two compare channels and one output flip-flop that drives a timer pin. Each channel holds a compare value. When the running counter reaches that value, the channel sends a one-clock interrupt pulse. The output flip-flop can be inverted by either compare match or by either of two capture-latch strobes. Each of these four sources has its own enable bit.

Software can also act on the flip-flop through a 2-bit command written with a write strobe. The command can invert the flip-flop, force it high, force it low, or do nothing. When a hardware inversion and a software command fall in the same cycle, a fixed rule decides the result. Software is expected to set or clear the flip-flop before it relies on the pin. Enable bits should only be changed while the counter is stopped.

Top module: `tmr_toggle_unit`

## Requirements
- R1: The counter advances by one on each clock while `run` is high. Whenever `run` is low, it becomes 0 on the next clock.
- R2: After 0xFFFF the counter rolls over to 0 and keeps counting, with no other effect.
- R3: `irq[k]` is high for exactly one clock. That clock directly follows a clock in which `run` was high and the counter equalled `cmp_val_k`.
- R4: A match on channel k inverts `tmr_out` in the same clock that `irq[k]` rises, but only if enable bit k is set. Enable bit 0 belongs to compare 0 and bit 1 to compare 1.
- R5: A capture strobe `cap_evt[j]` sampled high inverts `tmr_out` on the next clock, but only if enable bit 2+j is set.
- R6: A source whose enable bit is clear leaves `tmr_out` unchanged. If several enabled sources fire in the same clock, the flip-flop inverts only once.
- R7: When `cmd_we` is high, command value 00 inverts `tmr_out`, 01 sets it to 1, and 10 clears it to 0. The result appears on the next clock.
- R8: Command value 11, or `cmd_we` low, gives no software action. Only the hardware sources can then change `tmr_out`.
- R9: A hardware inversion and command 00 in the same clock invert `tmr_out` once.
- R10: A hardware inversion and command 01 in the same clock leave `tmr_out` at 1.
- R11: A hardware inversion and command 10 in the same clock leave `tmr_out` at 0.
- R12: While `rst` is high and on the clock after it, `count` is 0 and both `irq` bits are 0. Reset also clears `tmr_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Counter run enable |
| cmp_val0 | input | 16 | Compare value, channel 0 |
| cmp_val1 | input | 16 | Compare value, channel 1 |
| inv_en | input | 4 | Inversion enables: [0] match 0, [1] match 1, [2] capture 0, [3] capture 1 |
| cap_evt | input | 2 | Capture-latch strobes |
| cmd_we | input | 1 | Flip-flop command write strobe |
| cmd | input | 2 | Flip-flop command: 00 invert, 01 set, 10 clear, 11 none |
| count | output | 16 | Counter value |
| irq | output | 2 | Compare interrupt pulses |
| tmr_out | output | 1 | Timer flip-flop output |

## Verification
Every result is due one clock after the inputs that cause it are sampled. The counter step, each interrupt pulse and the flip-flop update all land on the edge that follows the clock in which the counter equalled a compare value, or in which a strobe or command was present. The bench drives inputs on the falling edge. Just after each rising edge it advances a cycle model written from the requirements, using the inputs that were held for that edge, and then compares all outputs. Same-cycle collisions are placed by starting the counter at 0 and issuing a command in the clock where the counter equals the compare value. The flip-flop is not checked until a command has defined its value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    FF_INV  = 2'b00,
    FF_SET  = 2'b01,
    FF_CLR  = 2'b10,
    FF_NONE = 2'b11
  } ff_cmd_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assert_stop_clears_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  assert_steps_R1: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
  assert_rollover_R2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == CNT_MAX) |=> (cnt == '0));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ref_val,
  output logic             hit,
  output logic             irq
);
  assign hit = run && (cnt == ref_val);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit;
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_pulse_follows_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == ref_val) |=> irq);
endmodule

// File: rtl/tmr_flop.sv
module tmr_flop
  import tmr_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en,
  input  logic            cmd_we,
  input  logic [1:0]      cmd,
  output logic            q
);
  logic    hw_flip;
  ff_cmd_e op;
  logic    nxt;

  assign hw_flip = |(src & en);
  assign op      = cmd_we ? ff_cmd_e'(cmd) : FF_NONE;

  always_comb begin
    unique case (op)
      FF_SET:  nxt = 1'b1;
      FF_CLR:  nxt = 1'b0;
      FF_INV:  nxt = ~q;
      default: nxt = hw_flip ? ~q : q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd == 2'b01) |=> q);
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd == 2'b10) |=> !q);
  assert_invert_once_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd == 2'b00) |=> (q != $past(q)));
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((!cmd_we || cmd == 2'b11) && (src & en) == '0) |=> $stable(q));
  assert_hw_flip_R6: assert property (@(posedge clk) disable iff (rst)
    ((!cmd_we || cmd == 2'b11) && (src & en) != '0) |=> (q != $past(q)));
endmodule

// File: rtl/tmr_toggle_unit.sv
module tmr_toggle_unit #(
  parameter int CNT_W = 16,
  parameter int N_CMP = 2,
  parameter int N_CAP = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic [CNT_W-1:0]       cmp_val0,
  input  logic [CNT_W-1:0]       cmp_val1,
  input  logic [N_CMP+N_CAP-1:0] inv_en,
  input  logic [N_CAP-1:0]       cap_evt,
  input  logic                   cmd_we,
  input  logic [1:0]             cmd,
  output logic [CNT_W-1:0]       count,
  output logic [N_CMP-1:0]       irq,
  output logic                   tmr_out
);
  localparam int NSRC = N_CMP + N_CAP;

  logic [CNT_W-1:0] ref_arr [N_CMP];
  logic [N_CMP-1:0] hit;

  assign ref_arr[0] = cmp_val0;
  assign ref_arr[1] = cmp_val1;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .cnt(count)
  );

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    tmr_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst(rst), .run(run), .cnt(count),
      .ref_val(ref_arr[k]), .hit(hit[k]), .irq(irq[k])
    );
  end

  tmr_flop #(.NSRC(NSRC)) u_ff (
    .clk(clk), .rst(rst), .src({cap_evt, hit}), .en(inv_en),
    .cmd_we(cmd_we), .cmd(cmd), .q(tmr_out)
  );

  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (count == '0 && irq == '0 && !tmr_out));
  assert_toggle_with_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (!cmd_we && cap_evt == '0 && inv_en[0] && !inv_en[1] && run && count == cmp_val0)
    |=> (irq[0] && tmr_out != $past(tmr_out)));
endmodule

// File: tb/tmr_toggle_unit_bench.sv
module tmr_toggle_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [15:0] cmp_val0 = '0, cmp_val1 = '0;
  logic [3:0]  inv_en = '0;
  logic [1:0]  cap_evt = '0;
  logic        cmd_we = 1'b0;
  logic [1:0]  cmd = 2'b11;
  logic [15:0] count;
  logic [1:0]  irq;
  logic        tmr_out;

  int checks = 0, fails = 0;
  logic [15:0] m_cnt = '0;
  logic [1:0]  m_irq = '0;
  logic        m_ff = 1'b0;
  logic        ff_known = 1'b0;

  always #2 clk = ~clk;

  tmr_toggle_unit u_tmr_toggle_unit (
    .clk(clk), .rst(rst), .run(run), .cmp_val0(cmp_val0), .cmp_val1(cmp_val1),
    .inv_en(inv_en), .cap_evt(cap_evt), .cmd_we(cmd_we), .cmd(cmd),
    .count(count), .irq(irq), .tmr_out(tmr_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs set on the falling edge, model advanced and outputs compared after the rising edge
  task automatic step(input string tag, input logic r, input logic [1:0] cap,
                      input logic we, input logic [1:0] c);
    logic m0, m1, hw;
    @(negedge clk);
    run = r; cap_evt = cap; cmd_we = we; cmd = c;
    @(posedge clk);
    m0 = r && (m_cnt == cmp_val0);
    m1 = r && (m_cnt == cmp_val1);
    hw = (inv_en[0] & m0) | (inv_en[1] & m1) | (inv_en[2] & cap[0]) | (inv_en[3] & cap[1]);
    if (we && c == 2'b01)      begin m_ff = 1'b1; ff_known = 1'b1; end
    else if (we && c == 2'b10) begin m_ff = 1'b0; ff_known = 1'b1; end
    else if (we && c == 2'b00) m_ff = ~m_ff;
    else if (hw)               m_ff = ~m_ff;
    m_irq = {m1, m0};
    m_cnt = r ? m_cnt + 16'd1 : 16'd0;
    #1;
    chk({tag, " R1 count"}, count, m_cnt);
    chk({tag, " R3 irq"}, {14'd0, irq}, {14'd0, m_irq});
    if (ff_known) chk({tag, " R4-out"}, {15'd0, tmr_out}, {15'd0, m_ff});
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset count", count, 16'd0);
    chk("R12 reset irq", {14'd0, irq}, 16'd0);
    @(negedge clk); rst = 1'b0;
    step("R12", 1'b0, 2'b00, 1'b0, 2'b11);

    // R7 basic commands from stopped state
    step("R7 set", 1'b0, 2'b00, 1'b1, 2'b01);
    step("R7 clr", 1'b0, 2'b00, 1'b1, 2'b10);
    step("R7 inv", 1'b0, 2'b00, 1'b1, 2'b00);
    step("R8 nop", 1'b0, 2'b00, 1'b1, 2'b11);
    step("R8 idle", 1'b0, 2'b00, 1'b0, 2'b00);

    // R4 R5 R6: sweep all enable masks with varying capture strobes and commands
    for (int en = 0; en < 16; en++) begin
      step("R6 stop", 1'b0, 2'b00, 1'b0, 2'b11);
      inv_en = en[3:0];
      cmp_val0 = 16'(en * 3 + 2);
      cmp_val1 = 16'(en * 5 + 7);
      for (int i = 0; i < 48; i++) begin
        logic [1:0] cp;
        cp = 2'((i * 7 + en) % 5);
        step("R5 sweep", 1'b1, cp, (i % 9 == 4), 2'(i / 9));
      end
    end

    // R9 R10 R11 R8: command lands in the clock where channel 0 matches
    for (int c = 0; c < 4; c++) begin
      step("R11 stop", 1'b0, 2'b00, 1'b1, 2'b10);
      inv_en = 4'b0001; cmp_val0 = 16'd4; cmp_val1 = 16'd200;
      for (int i = 0; i < 4; i++) step("R4 run", 1'b1, 2'b00, 1'b0, 2'b11);
      step("R9 collide", 1'b1, 2'b00, 1'b1, 2'(c));
      case (c)
        0: chk("R9 invert once", {15'd0, tmr_out}, 16'd1);
        1: chk("R10 set wins", {15'd0, tmr_out}, 16'd1);
        2: chk("R11 clear wins", {15'd0, tmr_out}, 16'd0);
        default: chk("R8 nop keeps hw flip", {15'd0, tmr_out}, 16'd1);
      endcase
      chk("R3 irq with collision", {14'd0, irq}, 16'd1);
      step("R3 after", 1'b1, 2'b00, 1'b0, 2'b11);
    end

    // R1: stopping clears the counter
    step("R1 stop", 1'b0, 2'b00, 1'b0, 2'b11);
    chk("R1 cleared", count, 16'd0);

    // R2: full rollover with compares at both ends
    inv_en = 4'b0011; cmp_val0 = 16'hFFFF; cmp_val1 = 16'h0000;
    for (int i = 0; i < 65540; i++) step("R2 wrap", 1'b1, 2'b00, 1'b0, 2'b11);
    step("R1 end", 1'b0, 2'b00, 1'b0, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule